// File: doc/BRIEF.md
# Host Port Slave with Halfword Register Access

This block lets an external host processor read and write an internal 32-bit word memory over a 16-bit data path. The host asserts chip select and a data strobe. A two-bit select field picks one of three registers: a control register, an address register, or a data register that maps onto the memory word the address register points at. The data register has two select codes. One leaves the address unchanged. The other moves the address on by one word when a full word has been transferred.

Every 32-bit register moves as two 16-bit halves. A halfword input names which half is being transferred. Two byte enables qualify each write. Hosts that put address and data on the same wires can pulse an address-latch strobe to capture the select, halfword and direction inputs ahead of the data phase. Hosts that do not need it tie the strobe high.

A ready output drops while a memory fetch is pending. An interrupt output is raised by a request from the core side, and the host clears it through the control register. Host pins are asynchronous and pass through a two-flop synchroniser. The data path is split into an input, an output and an output enable, and the pad driver sits outside the block.

Top module: `host_port_slave`

## Requirements
- R1: `hst_dat_oe` is 1 only during a read access, which runs from the strobe going low to the strobe going high while chip select is low. It is 0 during writes, while idle, and while the strobe is low with chip select high.
- R2: The select code chooses the register: 00 is control, 01 is data with auto-increment, 10 is address, and 11 is data with the address left unchanged.
- R3: With halfword input 0 the transfer carries bits 15:0 of the selected register, and with halfword input 1 it carries bits 31:16. Select, halfword and direction are taken when the strobe goes low.
- R4: A data-register write with halfword 0 is only staged. Memory is written once, when a write with halfword 1 completes, using the staged low half and the new high half.
- R5: Byte enable bit 0 qualifies bits 7:0 of the transferred halfword, and bit 1 qualifies bits 15:8. Bytes that are not enabled keep their old value, in memory and in the address register.
- R6: On completion of a halfword-1 transfer with select 01, the address register increases by one, for reads and for writes. Select 11 leaves the address unchanged.
- R7: A data-register read with halfword 0 drops `hst_rdy` for exactly one clock, the third clock edge after the strobe goes low. Reads of the address or control register leave `hst_rdy` at 1.
- R8: A one-cycle pulse on `core_int_req` sets the interrupt flag, and `hst_int` follows the flag. The flag reads back as bit 0 of the control register. Writing 1 to that bit with halfword 0 and byte enable bit 0 set clears the flag. Writing 0, or writing the high half, leaves it set.
- R9: When `hst_ale_n` goes low, the select, halfword and direction inputs are latched and used for the next access in place of the live pins. An access started with no latch pending uses the live pins.
- R10: After reset `hst_dat_oe` is 0, `hst_rdy` is 1, `hst_int` is 0 and the address register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_strb_n | input | 1 | Host data strobe, active low |
| hst_ale_n | input | 1 | Address-latch strobe, active low; tied high when unused |
| hst_sel | input | 2 | Register select code |
| hst_half | input | 1 | Halfword select: 0 low, 1 high |
| hst_rnw | input | 1 | Direction: 1 read, 0 write |
| hst_be | input | 2 | Write byte enables for the halfword |
| hst_dat_i | input | 16 | Write data from the host |
| hst_dat_o | output | 16 | Read data to the host |
| hst_dat_oe | output | 1 | Drive enable for the external data pads |
| hst_rdy | output | 1 | Ready; 0 while a memory fetch is pending |
| hst_int | output | 1 | Interrupt to the host |
| core_int_req | input | 1 | Core-side request that sets the interrupt flag |

## Verification
The strobe takes two clock edges to pass the synchroniser, so the start of an access is acted on at the third edge. That is when ready drops for a data read. The fetched word is valid after the fourth edge. The end of an access likewise reaches the registers at its third edge, and a memory write lands one edge later. The bench changes pins on falling clock edges and waits five falling edges after each strobe change before it samples. The ready check samples the third and fourth falling edges after the strobe goes low, to confirm a single-cycle drop at the computed edge.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_DINC = 2'b01,
        SEL_ADDR = 2'b10,
        SEL_DFIX = 2'b11
    } sel_e;

    // Both data-register codes have bit 0 set
    function automatic logic sel_is_data(input sel_e s);
        return s[0];
    endfunction

    function automatic logic [15:0] hp_merge(input logic [15:0] old_v,
                                             input logic [15:0] new_v,
                                             input logic [1:0]  be);
        logic [15:0] r;
        r = old_v;
        if (be[0]) r[7:0]  = new_v[7:0];
        if (be[1]) r[15:8] = new_v[15:8];
        return r;
    endfunction

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
    parameter int             W      = 2,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prv_o
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] pipe_d [DEPTH];
    logic [W-1:0] pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = raw_i;
        for (int i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= RST;
        end else begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign lvl_o = pipe_q[STAGES-1];
    assign prv_o = pipe_q[STAGES];
endmodule

// File: rtl/hps_ram.sv
module hps_ram #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [3:0]    wbe,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int LANES = 4;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] rd_q;
        always_ff @(posedge clk) begin
            if (we && wbe[g]) mem[waddr] <= wdata[g*8 +: 8];
            if (re)           rd_q       <= mem[raddr];
        end
        assign rdata[g*8 +: 8] = rd_q;
    end
endmodule

// File: rtl/hps_core.sv
module hps_core
    import hps_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_lvl,
    input  logic          acc_prv,
    input  logic          ale_lvl,
    input  logic          ale_prv,
    input  logic [1:0]    sel_i,
    input  logic          half_i,
    input  logic          rnw_i,
    input  logic [1:0]    be_i,
    input  logic [15:0]   dat_i,
    input  logic          int_req,
    output logic [15:0]   dat_o,
    output logic          dat_oe,
    output logic          rdy,
    output logic          int_o,
    output logic          ram_we,
    output logic [3:0]    ram_wbe,
    output logic [AW-1:0] ram_waddr,
    output logic [31:0]   ram_wdata,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    input  logic [31:0]   ram_rdata
);
    typedef struct packed {
        logic [31:0]   addr;
        logic          flag;
        logic [15:0]   stg_dat;
        logic [1:0]    stg_be;
        sel_e          sel;
        logic          half;
        logic          rnw;
        logic          busy;
        sel_e          lsel;
        logic          lhalf;
        logic          lrnw;
        logic          lvld;
        logic          fetch;
        logic          we;
        logic [3:0]    wbe;
        logic [31:0]   wdat;
        logic [AW-1:0] waddr;
    } st_t;

    st_t  s_q, s_d;
    logic acc_start, acc_end, ale_start;
    sel_e e_sel;
    logic e_half, e_rnw;
    logic [31:0] rd_word;

    assign acc_start = acc_lvl & ~acc_prv;
    assign acc_end   = ~acc_lvl & acc_prv;
    assign ale_start = ale_lvl & ~ale_prv;

    always_comb begin
        s_d        = s_q;
        s_d.fetch  = 1'b0;
        s_d.we     = 1'b0;
        e_sel      = s_q.lvld ? s_q.lsel  : sel_e'(sel_i);
        e_half     = s_q.lvld ? s_q.lhalf : half_i;
        e_rnw      = s_q.lvld ? s_q.lrnw  : rnw_i;

        if (acc_end && s_q.busy) begin
            s_d.busy = 1'b0;
            s_d.lvld = 1'b0;
            if (!s_q.rnw) begin
                unique case (s_q.sel)
                    SEL_ADDR: begin
                        if (s_q.half) s_d.addr[31:16] = hp_merge(s_q.addr[31:16], dat_i, be_i);
                        else          s_d.addr[15:0]  = hp_merge(s_q.addr[15:0],  dat_i, be_i);
                    end
                    SEL_CTRL: begin
                        if (!s_q.half && be_i[0] && dat_i[0]) s_d.flag = 1'b0;
                    end
                    default: begin
                        if (!s_q.half) begin
                            s_d.stg_dat = dat_i;
                            s_d.stg_be  = be_i;
                        end else begin
                            s_d.we     = 1'b1;
                            s_d.wbe    = {be_i, s_q.stg_be};
                            s_d.wdat   = {dat_i, s_q.stg_dat};
                            s_d.waddr  = s_q.addr[AW-1:0];
                            s_d.stg_be = 2'b00;
                        end
                    end
                endcase
            end
            if (s_q.sel == SEL_DINC && s_q.half) s_d.addr = s_q.addr + 32'd1;
        end

        if (ale_start) begin
            s_d.lsel  = sel_e'(sel_i);
            s_d.lhalf = half_i;
            s_d.lrnw  = rnw_i;
            s_d.lvld  = 1'b1;
        end

        if (acc_start) begin
            s_d.sel   = e_sel;
            s_d.half  = e_half;
            s_d.rnw   = e_rnw;
            s_d.busy  = 1'b1;
            s_d.fetch = e_rnw && sel_is_data(e_sel) && !e_half;
        end

        if (int_req) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sel  <= SEL_CTRL;
            s_q.lsel <= SEL_CTRL;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.sel)
            SEL_CTRL: rd_word = {31'd0, s_q.flag};
            SEL_ADDR: rd_word = s_q.addr;
            default:  rd_word = ram_rdata;
        endcase
    end

    assign dat_o     = s_q.half ? rd_word[31:16] : rd_word[15:0];
    assign dat_oe    = s_q.busy & s_q.rnw;
    assign rdy       = ~s_q.fetch;
    assign int_o     = s_q.flag;
    assign ram_re    = s_q.fetch;
    assign ram_raddr = s_q.addr[AW-1:0];
    assign ram_we    = s_q.we;
    assign ram_wbe   = s_q.wbe;
    assign ram_waddr = s_q.waddr;
    assign ram_wdata = s_q.wdat;

    // R7
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> rdy);

    // R4
    mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(acc_end && s_q.busy && !s_q.rnw && s_q.half));

    // R6
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end && s_q.busy && s_q.sel == SEL_DFIX) |=> $stable(s_q.addr));

    // R1
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_end |=> !dat_oe);

    // R8
    int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |=> int_o);
endmodule

// File: rtl/host_port_slave.sv
module host_port_slave #(
    parameter int AW     = 6,
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_cs_n,
    input  logic        hst_strb_n,
    input  logic        hst_ale_n,
    input  logic [1:0]  hst_sel,
    input  logic        hst_half,
    input  logic        hst_rnw,
    input  logic [1:0]  hst_be,
    input  logic [15:0] hst_dat_i,
    output logic [15:0] hst_dat_o,
    output logic        hst_dat_oe,
    output logic        hst_rdy,
    output logic        hst_int,
    input  logic        core_int_req
);
    logic [1:0]    raw, lvl, prv;
    logic          ram_we, ram_re;
    logic [3:0]    ram_wbe;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [31:0]   ram_wdata, ram_rdata;

    // bit 0: access active, bit 1: address latch active
    assign raw = {~hst_ale_n, ~hst_cs_n & ~hst_strb_n};

    hps_sync #(.W(2), .STAGES(STAGES), .RST(2'b00)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    hps_core #(.AW(AW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_lvl   (lvl[0]),
        .acc_prv   (prv[0]),
        .ale_lvl   (lvl[1]),
        .ale_prv   (prv[1]),
        .sel_i     (hst_sel),
        .half_i    (hst_half),
        .rnw_i     (hst_rnw),
        .be_i      (hst_be),
        .dat_i     (hst_dat_i),
        .int_req   (core_int_req),
        .dat_o     (hst_dat_o),
        .dat_oe    (hst_dat_oe),
        .rdy       (hst_rdy),
        .int_o     (hst_int),
        .ram_we    (ram_we),
        .ram_wbe   (ram_wbe),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .ram_re    (ram_re),
        .ram_raddr (ram_raddr),
        .ram_rdata (ram_rdata)
    );

    hps_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .wbe   (ram_wbe),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );
endmodule

// File: tb/host_port_slave_test.sv
`timescale 1ns/1ps
module host_port_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, strb_n = 1'b1, ale_n = 1'b1;
    logic [1:0]  sel = 2'b00;
    logic        half = 1'b0, rnw = 1'b1;
    logic [1:0]  be = 2'b00;
    logic [15:0] din = 16'h0000;
    logic        int_req = 1'b0;
    logic [15:0] dout;
    logic        oe, rdy, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    host_port_slave uut (
        .clk(clk), .rst_n(rst_n), .hst_cs_n(cs_n), .hst_strb_n(strb_n),
        .hst_ale_n(ale_n), .hst_sel(sel), .hst_half(half), .hst_rnw(rnw),
        .hst_be(be), .hst_dat_i(din), .hst_dat_o(dout), .hst_dat_oe(oe),
        .hst_rdy(rdy), .hst_int(irq), .core_int_req(int_req)
    );

    // {req, sel, half, rnw, be, write data, expected read}
    localparam int NV = 26;
    localparam logic [41:0] VEC [NV] = '{
        {4'd10, 2'b10, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0000}, // R10 address after reset
        {4'd2,  2'b10, 1'b0, 1'b0, 2'b11, 16'h0005, 16'h0000}, // R2
        {4'd3,  2'b10, 1'b1, 1'b0, 2'b11, 16'h0000, 16'h0000}, // R3
        {4'd3,  2'b10, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0005}, // R3
        {4'd4,  2'b11, 1'b0, 1'b0, 2'b11, 16'h1234, 16'h0000}, // R4
        {4'd4,  2'b11, 1'b1, 1'b0, 2'b11, 16'hABCD, 16'h0000}, // R4
        {4'd4,  2'b11, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h1234}, // R4
        {4'd3,  2'b11, 1'b1, 1'b1, 2'b00, 16'h0000, 16'hABCD}, // R3
        {4'd6,  2'b10, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0005}, // R6 fixed mode
        {4'd6,  2'b01, 1'b0, 1'b0, 2'b11, 16'h5678, 16'h0000}, // R6
        {4'd6,  2'b01, 1'b1, 1'b0, 2'b11, 16'h9ABC, 16'h0000}, // R6
        {4'd6,  2'b10, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0006}, // R6 write increment
        {4'd5,  2'b10, 1'b0, 1'b0, 2'b01, 16'hFF05, 16'h0000}, // R5
        {4'd5,  2'b10, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0005}, // R5 high byte kept
        {4'd6,  2'b01, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h5678}, // R6
        {4'd6,  2'b01, 1'b1, 1'b1, 2'b00, 16'h0000, 16'h9ABC}, // R6
        {4'd6,  2'b10, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0006}, // R6 read increment
        {4'd2,  2'b10, 1'b0, 1'b0, 2'b11, 16'h0005, 16'h0000}, // R2
        {4'd5,  2'b11, 1'b0, 1'b0, 2'b01, 16'hFFEE, 16'h0000}, // R5
        {4'd5,  2'b11, 1'b1, 1'b0, 2'b10, 16'h77FF, 16'h0000}, // R5
        {4'd5,  2'b11, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h56EE}, // R5
        {4'd5,  2'b11, 1'b1, 1'b1, 2'b00, 16'h0000, 16'h77BC}, // R5
        {4'd4,  2'b11, 1'b0, 1'b0, 2'b11, 16'h1111, 16'h0000}, // R4 staged only
        {4'd4,  2'b11, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h56EE}, // R4 memory untouched
        {4'd8,  2'b00, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0000}, // R8 flag clear
        {4'd3,  2'b10, 1'b1, 1'b1, 2'b00, 16'h0000, 16'h0000}  // R3 high half
    };

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic xfer(input logic [1:0] s, input logic h, input logic r,
                        input logic [1:0] b, input logic [15:0] wd,
                        input logic [15:0] exp, input int req);
        @(negedge clk);
        sel = s; half = h; rnw = r; be = b; din = wd;
        cs_n = 1'b0; strb_n = 1'b0;
        wait_neg(5);
        if (r) begin
            check(dout == exp, req, {16'h0, dout}, {16'h0, exp});
            check(oe == 1'b1, 1, {31'h0, oe}, 32'h1);            // R1
        end else begin
            check(oe == 1'b0, 1, {31'h0, oe}, 32'h0);            // R1
        end
        strb_n = 1'b1;
        wait_neg(5);
        cs_n = 1'b1;
        wait_neg(1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_neg(3);
        // R10 reset state
        check(oe == 1'b0,  10, {31'h0, oe},  32'h0);
        check(rdy == 1'b1, 10, {31'h0, rdy}, 32'h1);
        check(irq == 1'b0, 10, {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        wait_neg(2);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][37:36], VEC[i][35], VEC[i][34], VEC[i][33:32],
                 VEC[i][31:16], VEC[i][15:0], int'(VEC[i][41:38]));
        end

        // R1: strobe low with chip select high drives nothing
        sel = 2'b10; rnw = 1'b1; cs_n = 1'b1; strb_n = 1'b0;
        wait_neg(5);
        check(oe == 1'b0, 1, {31'h0, oe}, 32'h0);
        strb_n = 1'b1;
        wait_neg(2);

        // R7: data low-half read drops ready for one clock
        sel = 2'b11; half = 1'b0; rnw = 1'b1; cs_n = 1'b0; strb_n = 1'b0;
        wait_neg(2);
        check(rdy == 1'b1, 7, {31'h0, rdy}, 32'h1);
        wait_neg(1);
        check(rdy == 1'b0, 7, {31'h0, rdy}, 32'h0);
        wait_neg(1);
        check(rdy == 1'b1, 7, {31'h0, rdy}, 32'h1);
        strb_n = 1'b1;
        wait_neg(5);
        cs_n = 1'b1;
        wait_neg(1);

        // R7: address read never drops ready
        sel = 2'b10; half = 1'b0; rnw = 1'b1; cs_n = 1'b0; strb_n = 1'b0;
        begin
            bit seen_low = 1'b0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (!rdy) seen_low = 1'b1;
            end
            check(!seen_low, 7, {31'h0, seen_low}, 32'h0);
        end
        strb_n = 1'b1;
        wait_neg(5);
        cs_n = 1'b1;
        wait_neg(1);

        // R8: interrupt set, read back, ignored writes, clear
        @(negedge clk);
        int_req = 1'b1;
        @(negedge clk);
        int_req = 1'b0;
        check(irq == 1'b1, 8, {31'h0, irq}, 32'h1);
        xfer(2'b00, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0001, 8);
        xfer(2'b00, 1'b0, 1'b0, 2'b11, 16'h0000, 16'h0000, 8);
        check(irq == 1'b1, 8, {31'h0, irq}, 32'h1);
        xfer(2'b00, 1'b1, 1'b0, 2'b11, 16'h0001, 16'h0000, 8);
        check(irq == 1'b1, 8, {31'h0, irq}, 32'h1);
        xfer(2'b00, 1'b0, 1'b0, 2'b11, 16'h0001, 16'h0000, 8);
        check(irq == 1'b0, 8, {31'h0, irq}, 32'h0);

        // R9: latched controls override live pins
        xfer(2'b10, 1'b0, 1'b0, 2'b11, 16'h0033, 16'h0000, 2);
        @(negedge clk);
        sel = 2'b10; half = 1'b0; rnw = 1'b1; ale_n = 1'b0;
        wait_neg(4);
        ale_n = 1'b1;
        sel = 2'b00; half = 1'b1; rnw = 1'b0; din = 16'hFFFF; be = 2'b11;
        cs_n = 1'b0; strb_n = 1'b0;
        wait_neg(5);
        check(oe == 1'b1, 9, {31'h0, oe}, 32'h1);
        check(dout == 16'h0033, 9, {16'h0, dout}, 32'h0033);
        strb_n = 1'b1;
        wait_neg(5);
        cs_n = 1'b1;
        wait_neg(1);
        // R9: latch consumed, live pins used again
        xfer(2'b10, 1'b0, 1'b1, 2'b00, 16'h0000, 16'h0033, 9);

        finish_run();
    end
endmodule